// File: doc/BRIEF.md
# Selectable-Source Baud Tick Generator

This block produces the baud-rate enable pulse for one serial port. A single 32-bit configuration word picks one of two reference strobes and sets an integer divisor. The two references are clock-enable strobes in the system clock domain: a slow one at nominally 3 MHz and a fast one at about 12 MHz. The block counts strobes from the selected reference. On every Nth strobe it raises a tick for one system-clock cycle, where N is the divisor. The serializer and deserializer of the port use this tick.

The source-select field has a code for "off", and a divisor of zero also stops the output. Either one silences the port. The bits above the select field are not implemented: they always read back as zero. Any write to the configuration word restarts the divider, so the first tick at a new rate comes a full new period after the write. For example, the word 0x1001A divides the slow reference by 26, and 0x2000D divides the fast reference by 13.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the configuration word reads 0x00000000 and `baud_tick` stays low.
- R2: Bits 31:18 of the configuration word always read as zero, and whatever is written to them has no effect.
- R3: Bits 17:16 (source select) and bits 15:0 (divisor) read back exactly as last written, starting the cycle after the write.
- R4: With source select 00 no tick is produced and the divider holds at zero, whatever the divisor and strobe inputs are.
- R5: With source select 01 only `slow_stb` is counted, and `fast_stb` has no effect on the tick pattern.
- R6: With source select 10 or 11 only `fast_stb` is counted, and `slow_stb` has no effect. The codes 10 and 11 behave identically.
- R7: With divisor N > 0 and an active source, `baud_tick` is high for exactly the one cycle after every Nth counted strobe, counting from the last write or reset.
- R8: A divisor of 1 gives a tick after every strobe of the selected source, so the reference passes through at full rate.
- R9: A divisor of 0 produces no ticks on either source.
- R10: A write to the configuration word clears the divider. A strobe in the same cycle as the write is not counted, and no tick follows that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Current configuration word (unimplemented bits read zero) |
| slow_stb | input | 1 | Slow reference clock-enable strobe |
| fast_stb | input | 1 | Fast reference clock-enable strobe |
| baud_tick | output | 1 | One-cycle baud enable pulse |

## Verification
The bench builds the block with its default 32-bit word and 16-bit divisor. This keeps the real register layout, so full words such as 0x1001A and 0x2000D can be written directly. Random phases mostly use divisors from 0 to 6 with random strobe densities, so complete wrap cycles, restarts in the middle of a count, and strobes that coincide with writes happen many times. A directed run with divisor 26 on the slow source checks a realistic period without taking many cycles.

// File: rtl/baudgen_pkg.sv
// Package: shared widths, field positions and the source-select encoding
// for the baud tick generator. Assumes a 32-bit word, with the select field
// sitting directly above the divisor.
package baudgen_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned DIV_W    = 16;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned SEL_LSB  = DIV_W;
    localparam int unsigned USED_W   = DIV_W + SEL_W;

    // Mask of the implemented bits in the configuration word.
    localparam logic [WORD_W-1:0] CFG_MASK = {{(WORD_W-USED_W){1'b0}}, {USED_W{1'b1}}};

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF   = 2'b00,
        SRC_SLOW  = 2'b01,
        SRC_FAST  = 2'b10,
        SRC_FAST2 = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e         sel;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/baudgen_cfg_reg.sv
// Module: configuration word storage.
// Keeps only the implemented bits. Unimplemented bits are dropped on write
// and return zero on read. Emits a one-cycle restart request on every write.
// Assumes a synchronous active-low reset and writes from a single master.
module baudgen_cfg_reg
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output cfg_t              cfg_o,
    output logic              restart_o
);
    logic [WORD_W-1:0] word_q;

    // Capture the masked word on write, and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en_i) begin
            word_q <= wr_data_i & CFG_MASK;
        end
    end

    // Present the stored word and its decoded fields.
    always_comb begin
        rd_data_o = word_q;
        cfg_o     = cfg_t'(word_q[USED_W-1:0]);
        restart_o = wr_en_i;
    end

    // R2: the unimplemented bits never hold a one.
    always_comb begin
        if (rst_n) begin
            assert_upper_raz_R2: assert ((rd_data_o & ~CFG_MASK) == '0)
                else $error("upper bits of configuration word not zero");
        end
    end

    // R3: the stored implemented bits follow the last write.
    property p_readback;
        @(posedge clk) disable iff (!rst_n)
            wr_en_i |=> (rd_data_o[USED_W-1:0] == $past(wr_data_i[USED_W-1:0]));
    endproperty
    assert_readback_R3: assert property (p_readback)
        else $error("configuration readback mismatch");
endmodule

// File: rtl/baudgen_src_sel.sv
// Module: reference strobe selector.
// Routes the strobe picked by the select field, and reports whether the
// divider may run (source on and divisor nonzero). Purely combinational.
module baudgen_src_sel
    import baudgen_pkg::*;
(
    input  cfg_t cfg_i,
    input  logic slow_stb_i,
    input  logic fast_stb_i,
    output logic stb_o,
    output logic run_o
);
    // Choose the reference strobe; both fast codes map to the fast source.
    always_comb begin
        unique case (cfg_i.sel)
            SRC_OFF:             stb_o = 1'b0;
            SRC_SLOW:            stb_o = slow_stb_i;
            SRC_FAST, SRC_FAST2: stb_o = fast_stb_i;
            default:             stb_o = 1'b0;
        endcase
    end

    // The divider is allowed to run only with a live source and a divisor above zero.
    always_comb begin
        run_o = (cfg_i.sel != SRC_OFF) && (cfg_i.div != '0);
    end
endmodule

// File: rtl/baudgen_divider.sv
// Module: strobe-counting divider.
// Counts input strobes and raises a registered one-cycle tick after the
// strobe that completes each group of div_i strobes. clear_i or a stopped
// run_i forces the count to zero. Assumes div_i changes only together with
// a clear.
module baudgen_divider #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             stb_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap;

    // Work out the next count and whether this strobe closes a period.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        wrap    = (cnt_inc == div_i);
    end

    // Advance the count on each strobe, and emit the tick on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !run_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (stb_i) begin
            cnt_q  <= wrap ? '0 : cnt_inc;
            tick_o <= wrap;
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R7: a tick only follows a counted strobe in a running, uncleared cycle.
    property p_tick_cause;
        @(posedge clk) disable iff (!rst_n)
            tick_o |-> ($past(stb_i) && $past(run_i) && !$past(clear_i));
    endproperty
    assert_tick_cause_R7: assert property (p_tick_cause)
        else $error("tick without a counted strobe");

    // R7: the count stays below the divisor while running.
    property p_count_bound;
        @(posedge clk) disable iff (!rst_n)
            (run_i && !clear_i) |-> (cnt_q < div_i);
    endproperty
    assert_count_bound_R7: assert property (p_count_bound)
        else $error("divider count at or beyond divisor");

    // R4: a stopped divider holds its count at zero.
    property p_hold_zero;
        @(posedge clk) disable iff (!rst_n)
            !run_i |=> (cnt_q == '0);
    endproperty
    assert_hold_zero_R4: assert property (p_hold_zero)
        else $error("stopped divider count not zero");
endmodule

// File: rtl/baud_tick_gen.sv
// Module: baud tick generator top.
// Joins the configuration word, the reference selector and the divider.
// Assumes both reference strobes are synchronous to clk, and that each is
// one cycle wide per reference period.
module baud_tick_gen
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [WORD_W-1:0] cfg_wr_data,
    output logic [WORD_W-1:0] cfg_rd_data,
    input  logic              slow_stb,
    input  logic              fast_stb,
    output logic              baud_tick
);
    cfg_t cfg;
    logic restart;
    logic sel_stb;
    logic run;

    baudgen_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en),
        .wr_data_i (cfg_wr_data),
        .rd_data_o (cfg_rd_data),
        .cfg_o     (cfg),
        .restart_o (restart)
    );

    baudgen_src_sel u_sel (
        .cfg_i      (cfg),
        .slow_stb_i (slow_stb),
        .fast_stb_i (fast_stb),
        .stb_o      (sel_stb),
        .run_o      (run)
    );

    baudgen_divider #(
        .CNT_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .run_i   (run),
        .stb_i   (sel_stb),
        .div_i   (cfg.div),
        .tick_o  (baud_tick)
    );

    // R4: the off code silences the output on the following cycle.
    property p_off_silent;
        @(posedge clk) disable iff (!rst_n)
            (cfg_rd_data[SEL_LSB +: SEL_W] == SRC_OFF) |=> !baud_tick;
    endproperty
    assert_off_silent_R4: assert property (p_off_silent)
        else $error("tick while source is off");

    // R9: a zero divisor silences the output on the following cycle.
    property p_zero_halt;
        @(posedge clk) disable iff (!rst_n)
            (cfg_rd_data[DIV_W-1:0] == '0) |=> !baud_tick;
    endproperty
    assert_zero_halt_R9: assert property (p_zero_halt)
        else $error("tick with zero divisor");

    // R10: no tick follows a write cycle.
    property p_write_restart;
        @(posedge clk) disable iff (!rst_n)
            cfg_wr_en |=> !baud_tick;
    endproperty
    assert_write_restart_R10: assert property (p_write_restart)
        else $error("tick right after a configuration write");
endmodule

// File: tb/baud_tick_gen_tb.sv
// Bench: directed corner cases plus seeded random stimulus, checked every
// cycle against a reference model built from the requirements.
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h0003_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        slow_stb = 1'b0;
    logic        fast_stb = 1'b0;
    logic        baud_tick;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned n_ticks  = 0;

    logic [31:0] m_cfg = '0;
    int unsigned m_cnt = 0;
    logic        m_tick = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .slow_stb    (slow_stb),
        .fast_stb    (fast_stb),
        .baud_tick   (baud_tick)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Requirement tag for the tick check, chosen from the model state.
    function automatic string tick_tag(input logic wr);
        logic [1:0]  s;
        logic [15:0] d;
        s = m_cfg[17:16];
        d = m_cfg[15:0];
        if (wr)         return "R10";
        if (s == 2'b00) return "R4";
        if (d == 16'd0) return "R9";
        if (d == 16'd1) return "R8";
        if (s == 2'b01) return "R5";
        return "R6";
    endfunction

    // One cycle: drive at negedge, predict, then check at the next negedge.
    task automatic step(input logic wr, input logic [31:0] data, input logic s, input logic f);
        logic sel_stb;
        string tag;
        cfg_wr_en   = wr;
        cfg_wr_data = data;
        slow_stb    = s;
        fast_stb    = f;
        tag = tick_tag(wr);
        sel_stb = (m_cfg[17:16] == 2'b01) ? s :
                  (m_cfg[17] == 1'b1)    ? f : 1'b0;
        if (wr) begin
            m_cfg  = data & MASK;
            m_cnt  = 0;
            m_tick = 1'b0;
        end else if (m_cfg[17:16] == 2'b00 || m_cfg[15:0] == 16'd0) begin
            m_cnt  = 0;
            m_tick = 1'b0;
        end else if (sel_stb) begin
            m_cnt++;
            if (m_cnt == int'(m_cfg[15:0])) begin
                m_cnt  = 0;
                m_tick = 1'b1;
            end else begin
                m_tick = 1'b0;
            end
        end else begin
            m_tick = 1'b0;
        end
        @(negedge clk);
        check(tag, {31'd0, baud_tick}, {31'd0, m_tick});
        if (baud_tick) n_ticks++;
        if (wr) begin
            check("R2", cfg_rd_data & ~MASK, 32'd0);
            check("R3", cfg_rd_data, m_cfg);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'hB0D5_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check("R1", cfg_rd_data, 32'd0);
        check("R1", {31'd0, baud_tick}, 32'd0);
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1, 1'b1);

        // R2/R3: an all-ones write keeps only the implemented bits.
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R2", cfg_rd_data, 32'h0003_FFFF);

        // R4: source off with a nonzero divisor and busy strobes.
        step(1'b1, 32'h0000_0001, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b1, 1'b1);

        // R8: divisor 1 on the slow source passes every strobe through.
        step(1'b1, 32'h0001_0001, 1'b0, 1'b0);
        n_ticks = 0;
        for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1, 1'b0);
        check("R8", n_ticks, 32'd12);

        // R5: slow source, divisor 26, fast strobes ignored.
        step(1'b1, 32'h0001_001A, 1'b0, 1'b0);
        n_ticks = 0;
        for (int i = 0; i < 26 * 4 * 2; i++) step(1'b0, '0, (i % 4) == 0, 1'b1);
        check("R5", n_ticks, 32'd2);

        // R6: codes 10 and 11 both count the fast strobe only.
        step(1'b1, 32'h0002_000D, 1'b0, 1'b0);
        n_ticks = 0;
        for (int i = 0; i < 39; i++) step(1'b0, '0, 1'b1, 1'b1);
        check("R6", n_ticks, 32'd3);
        step(1'b1, 32'h0003_000D, 1'b0, 1'b0);
        n_ticks = 0;
        for (int i = 0; i < 39; i++) step(1'b0, '0, 1'b1, 1'b1);
        check("R6", n_ticks, 32'd3);

        // R9: zero divisor on both sources.
        step(1'b1, 32'h0002_0000, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1, 1'b1);
        step(1'b1, 32'h0001_0000, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1, 1'b1);

        // R10: a write during a strobe restarts the count; R7 periodic ticks.
        step(1'b1, 32'h0002_0003, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b1, 32'h0002_0003, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b0, '0, 1'b0, 1'b1);

        // Random phase: mixed writes, divisors and strobe densities (R2..R10).
        for (int i = 0; i < 6000; i++) begin
            logic        w;
            logic [31:0] d;
            w = ($urandom_range(0, 19) == 0);
            d = $urandom;
            d[15:0] = 16'($urandom_range(0, 6));
            step(w, d, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule